// File: doc/BRIEF.md
# Serial Block-Write Clock-Enable Controller

This block lets a host on a two-wire serial bus switch six differential clock output pairs on and off. All six pairs are copies of one reference clock input. The block is a receive-only bus slave. It holds eight 8-bit configuration registers and samples the bus clock and data lines with its own system clock. A write always carries two leading bytes, a command byte and a count byte. The block acknowledges both and throws them away. The data bytes that follow land in register 0, then register 1, and so on upward. The host may stop after any complete byte.

A read returns a count byte first, then the whole register set in ascending order. Three bits in each of two registers gate the output pairs. A gated-off pair parks its true output low and its complement output high. An enable change is applied only while the sampled reference is low, so no output pulse is ever cut short.

Top module: `clkfan_ctrl`

## Requirements
- R1: The slave acknowledges the bus byte D2h as a write and D3h as a read. The 7-bit address is in bits 7..1 and the direction is in bit 0, where 1 means read. Any other address byte gets no acknowledge, and the slave waits for the next Start.
- R2: In a write, the two bytes that follow the address are each acknowledged. Their contents change no register.
- R3: Data bytes of a write go to register 0, 1, 2 and so on, in that order, each with an acknowledge. A Stop after any whole byte leaves the registers that were not reached unchanged.
- R4: In a write, data bytes beyond register 7 are acknowledged and discarded.
- R5: A read sends the value 8 first, then registers 0 to 7, MSB first. Each further byte that the host acknowledges reads as FFh, with SDA released.
- R6: After reset, registers 0 to 5 and register 7 hold FFh and register 6 holds 8Fh. All six pairs are enabled.
- R7: Pair p has an enable bit. For pairs 0, 1 and 2 it is bit 0, 2 and 4 of register 7. For pairs 3, 4 and 5 it is bit 0, 1 and 2 of register 6. A bit value of 1 enables the pair. On an enabled pair, out_t[p] follows ref_in and out_c[p] is its inverse, two system-clock edges later.
- R8: A disabled pair drives out_t[p] low and out_c[p] high.
- R9: A new enable value is applied only while the sampled ref_in is low. While ref_in stays high, each output keeps its level.
- R10: A repeated Start during a transaction sends the slave back to idle. The address that follows it is not acknowledged.
- R11: The slave pulls SDA low only for its acknowledges and for 0 bits it transmits. It never changes SDA while SCL is high, and SDA is released after a Stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus and the reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial bus clock line |
| sda_in | input | 1 | Serial bus data line, as seen on the wire |
| sda_pull | output | 1 | 1 pulls the open-drain data line low |
| ref_in | input | 1 | Reference clock to be fanned out |
| out_t | output | 6 | True outputs of the six pairs |
| out_c | output | 6 | Complement outputs of the six pairs |

## Verification
An output pair answers a ref_in change two system-clock edges later. The bench therefore drives ref_in on a falling edge and compares out_t and out_c four falling edges later. A bus line change reaches the slave's logic after two synchronizer stages plus one edge-detect stage. An acknowledge or a transmitted bit is therefore driven about four system-clock cycles after the SCL fall that calls for it. The bench keeps every SCL phase 12 cycles long and samples SDA just before SCL falls, well after that delay. A register write reaches the enable outputs only after the next low reference sample, so the bench models that pending state before it predicts the output pattern.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    localparam int NUM_REGS  = 8;
    localparam int REG_W     = 8;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int NUM_PAIRS = 6;
    localparam int HDR_BYTES = 2;                       // command + count, discarded
    localparam int NB_LIMIT  = HDR_BYTES + NUM_REGS;    // saturation point of the byte counter
    localparam int NB_W      = $clog2(NB_LIMIT + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } bus_st_e;

    // power-on contents: reserved bits high, register 6 upper control bits low
    function automatic logic [REG_W-1:0] reg_default(input int idx);
        return (idx == 6) ? 8'h8F : 8'hFF;
    endfunction

    // register holding the enable of pair p
    function automatic int en_reg(input int p);
        return (p < 3) ? 7 : 6;
    endfunction

    // bit within that register
    function automatic int en_bit(input int p);
        return (p < 3) ? 2 * p : p - 3;
    endfunction

endpackage

// File: rtl/twi_sampler.sv
module twi_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sh;
        logic [SYNC_STAGES-1:0] sda_sh;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sh   = {smp_q.scl_sh[SYNC_STAGES-2:0], scl_in};
        smp_d.sda_sh   = {smp_q.sda_sh[SYNC_STAGES-2:0], sda_in};
        smp_d.scl_prev = smp_q.scl_sh[SYNC_STAGES-1];
        smp_d.sda_prev = smp_q.sda_sh[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '1;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign scl_lvl   = smp_q.scl_sh[SYNC_STAGES-1];
    assign sda_lvl   = smp_q.sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~smp_q.scl_prev;
    assign scl_fall  = ~scl_lvl & smp_q.scl_prev;
    assign start_det = scl_lvl & smp_q.scl_prev & smp_q.sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & smp_q.scl_prev & ~smp_q.sda_prev & sda_lvl;

endmodule

// File: rtl/twi_block_slave.sv
module twi_block_slave
    import clkfan_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7 = 7'h69
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_rise,
    input  logic                      scl_fall,
    input  logic                      start_det,
    input  logic                      stop_det,
    input  logic                      sda_lvl,
    input  logic [NUM_REGS*REG_W-1:0] rd_flat,
    output logic                      sda_pull,
    output logic                      wr_en,
    output logic [IDX_W-1:0]          wr_idx,
    output logic [REG_W-1:0]          wr_data
);

    typedef struct packed {
        bus_st_e         st;
        logic [7:0]      sh;
        logic [3:0]      bits;
        logic            rd;
        logic            addr_ph;
        logic [NB_W-1:0] nb;
        logic            hack;
        logic            pull;
    } slv_t;

    localparam slv_t SLV_RST = '{st: ST_IDLE, sh: 8'h00, bits: 4'd0, rd: 1'b0,
                                 addr_ph: 1'b0, nb: '0, hack: 1'b0, pull: 1'b0};

    slv_t            slv_d, slv_q;
    logic [NB_W-1:0] rel;
    logic [7:0]      nxt;

    // byte sent at read position k: count, then registers, then released bus
    function automatic logic [7:0] pick(input logic [NB_W-1:0] k);
        if (k == '0) begin
            return 8'(NUM_REGS);
        end else if (int'(k) <= NUM_REGS) begin
            return rd_flat[(int'(k) - 1) * REG_W +: REG_W];
        end else begin
            return 8'hFF;
        end
    endfunction

    always_comb begin
        slv_d   = slv_q;
        rel     = slv_q.nb - NB_W'(HDR_BYTES);
        nxt     = pick(slv_q.nb);
        wr_en   = 1'b0;
        wr_idx  = rel[IDX_W-1:0];
        wr_data = slv_q.sh;

        case (slv_q.st)
            ST_IDLE: begin
                slv_d.pull = 1'b0;
                if (start_det) begin
                    slv_d.st      = ST_RX;
                    slv_d.addr_ph = 1'b1;
                    slv_d.bits    = 4'd0;
                    slv_d.nb      = '0;
                    slv_d.rd      = 1'b0;
                end
            end
            ST_RX: begin
                if (scl_rise) begin
                    slv_d.sh   = {slv_q.sh[6:0], sda_lvl};
                    slv_d.bits = slv_q.bits + 4'd1;
                end
                if (scl_fall && slv_q.bits == 4'd8) begin
                    if (slv_q.addr_ph) begin
                        if (slv_q.sh[7:1] == DEV_ADDR7) begin
                            slv_d.rd   = slv_q.sh[0];
                            slv_d.st   = ST_ACK;
                            slv_d.pull = 1'b1;
                        end else begin
                            slv_d.st = ST_IDLE;
                        end
                    end else begin
                        slv_d.st   = ST_ACK;
                        slv_d.pull = 1'b1;
                        if (slv_q.nb >= NB_W'(HDR_BYTES) && rel < NB_W'(NUM_REGS)) begin
                            wr_en = 1'b1;
                        end
                        if (slv_q.nb < NB_W'(NB_LIMIT)) begin
                            slv_d.nb = slv_q.nb + 1'b1;
                        end
                    end
                end
            end
            ST_ACK: begin
                if (scl_fall) begin
                    slv_d.addr_ph = 1'b0;
                    slv_d.bits    = 4'd0;
                    if (slv_q.rd) begin
                        slv_d.st   = ST_TX;
                        slv_d.sh   = nxt;
                        slv_d.pull = ~nxt[7];
                        slv_d.bits = 4'd1;
                        if (slv_q.nb < NB_W'(NB_LIMIT)) begin
                            slv_d.nb = slv_q.nb + 1'b1;
                        end
                    end else begin
                        slv_d.st   = ST_RX;
                        slv_d.pull = 1'b0;
                    end
                end
            end
            ST_TX: begin
                if (scl_fall) begin
                    if (slv_q.bits == 4'd8) begin
                        slv_d.st   = ST_TXACK;
                        slv_d.pull = 1'b0;
                    end else begin
                        slv_d.sh   = {slv_q.sh[6:0], 1'b1};
                        slv_d.pull = ~slv_q.sh[6];
                        slv_d.bits = slv_q.bits + 4'd1;
                    end
                end
            end
            ST_TXACK: begin
                if (scl_rise) begin
                    slv_d.hack = ~sda_lvl;
                end
                if (scl_fall) begin
                    if (slv_q.hack) begin
                        slv_d.st   = ST_TX;
                        slv_d.sh   = nxt;
                        slv_d.pull = ~nxt[7];
                        slv_d.bits = 4'd1;
                        if (slv_q.nb < NB_W'(NB_LIMIT)) begin
                            slv_d.nb = slv_q.nb + 1'b1;
                        end
                    end else begin
                        slv_d.st = ST_IDLE;
                    end
                end
            end
            default: slv_d = SLV_RST;
        endcase

        // Stop anywhere, or a Start inside a transaction, ends it
        if (stop_det || (start_det && slv_q.st != ST_IDLE)) begin
            slv_d.st   = ST_IDLE;
            slv_d.pull = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slv_q <= SLV_RST;
        end else begin
            slv_q <= slv_d;
        end
    end

    assign sda_pull = slv_q.pull;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import clkfan_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);

    logic [NUM_REGS-1:0][REG_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            regs_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= reg_default(i);
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_flat = regs_q;

endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank #(
    parameter int NUM_PAIRS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_in,
    input  logic [NUM_PAIRS-1:0] en_req,
    output logic [NUM_PAIRS-1:0] out_t,
    output logic [NUM_PAIRS-1:0] out_c
);

    typedef struct packed {
        logic                 ref_s;
        logic [NUM_PAIRS-1:0] en_act;
        logic [NUM_PAIRS-1:0] t;
        logic [NUM_PAIRS-1:0] c;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d       = gate_q;
        gate_d.ref_s = ref_in;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            // enables only move while the sampled reference is low
            gate_d.en_act[p] = gate_q.ref_s ? gate_q.en_act[p] : en_req[p];
            gate_d.t[p]      = gate_q.ref_s & gate_d.en_act[p];
            gate_d.c[p]      = ~(gate_q.ref_s & gate_d.en_act[p]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q.ref_s  <= 1'b0;
            gate_q.en_act <= '1;
            gate_q.t      <= '0;
            gate_q.c      <= '1;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign out_t = gate_q.t;
    assign out_c = gate_q.c;

endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
    import clkfan_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR7   = 7'h69
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 sda_pull,
    input  logic                 ref_in,
    output logic [NUM_PAIRS-1:0] out_t,
    output logic [NUM_PAIRS-1:0] out_c
);

    logic                      scl_lvl, sda_lvl;
    logic                      scl_rise, scl_fall, start_det, stop_det;
    logic                      wr_en;
    logic [IDX_W-1:0]          wr_idx;
    logic [REG_W-1:0]          wr_data;
    logic [NUM_REGS*REG_W-1:0] regs_flat;
    logic [NUM_PAIRS-1:0]      en_req;

    twi_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_block_slave #(.DEV_ADDR7(DEV_ADDR7)) u_slv (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl),
        .rd_flat   (regs_flat),
        .sda_pull  (sda_pull),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    cfg_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    // pair-to-bit mapping of the enables
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_en
        localparam int POS = en_reg(p) * REG_W + en_bit(p);
        assign en_req[p] = regs_flat[POS];
    end

    clk_gate_bank #(.NUM_PAIRS(NUM_PAIRS)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .en_req (en_req),
        .out_t  (out_t),
        .out_c  (out_c)
    );

endmodule

// File: rtl/clkfan_ctrl_chk.sv
module clkfan_ctrl_chk #(
    parameter int NUM_PAIRS = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 scl_lvl,
    input logic                 stop_det,
    input logic                 sda_pull,
    input logic                 ref_in,
    input logic [NUM_PAIRS-1:0] out_t,
    input logic [NUM_PAIRS-1:0] out_c
);

    // R11: the data line only moves while the sampled bus clock is low
    a_r11_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull));

    // R11: the line is free after a Stop
    a_r11_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    // R7, R8: the two halves of every pair stay complementary
    a_r7_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
        out_c == ~out_t);

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        // R9: a true output only falls after a low reference sample
        a_r9_fall_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(out_t[p]) |-> !$past(ref_in, 2));
        // R9: a true output only rises after a high reference sample
        a_r9_rise_follows_high: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_t[p]) |-> $past(ref_in, 2));
    end

endmodule

bind clkfan_ctrl clkfan_ctrl_chk #(.NUM_PAIRS(clkfan_pkg::NUM_PAIRS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .stop_det (stop_det),
    .sda_pull (sda_pull),
    .ref_in   (ref_in),
    .out_t    (out_t),
    .out_c    (out_c)
);

// File: tb/sim_clkfan_ctrl.sv
module sim_clkfan_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 12;   // system cycles per SCL phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       ref_r = 1'b0;
    logic       sda_pull;
    logic       sda_line;
    logic [5:0] out_t, out_c;

    assign sda_line = sda_drv & ~sda_pull;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clkfan_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .ref_in   (ref_r),
        .out_t    (out_t),
        .out_c    (out_c)
    );

    int         total = 0;
    int         bad = 0;
    string      exp_tag[$];
    logic [7:0] exp_val[$];
    logic [7:0] obs_val[$];
    logic [7:0] mdl [8];
    logic [7:0] pay [12];
    logic [5:0] app_en;

    task automatic expect_item(input string tag, input logic [7:0] v);
        exp_tag.push_back(tag);
        exp_val.push_back(v);
    endtask

    // monitor: pops each observation against the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            while (obs_val.size() > 0) begin
                logic [7:0] got;
                got = obs_val.pop_front();
                total++;
                if (exp_val.size() == 0) begin
                    bad++;
                    $display("FAIL none: unexpected item got=%h expected=nothing", got);
                end else begin
                    string      t;
                    logic [7:0] v;
                    t = exp_tag.pop_front();
                    v = exp_val.pop_front();
                    if (got !== v) begin
                        bad++;
                        $display("FAIL %s: got=%h expected=%h", t, got, v);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic start_c();
        sda_drv = 1'b1; wq();
        scl = 1'b1;     wq();
        sda_drv = 1'b0; wq();
        scl = 1'b0;     wq();
    endtask

    task automatic stop_c();
        sda_drv = 1'b0; wq();
        scl = 1'b1;     wq();
        sda_drv = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wq();
            scl = 1'b1;     wq();
            scl = 1'b0;     wq();
        end
        sda_drv = 1'b1; wq();
        scl = 1'b1;     wq();
        ack = sda_line;
        scl = 1'b0;     wq();
    endtask

    task automatic recv_byte(input logic ack_bit, output logic [7:0] b);
        sda_drv = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wq();
            scl = 1'b1; wq();
            b = {b[6:0], sda_line};
            scl = 1'b0;
        end
        sda_drv = ack_bit; wq();
        scl = 1'b1;        wq();
        scl = 1'b0;        wq();
        sda_drv = 1'b1;
    endtask

    // enable bit positions as stated in R7
    function automatic logic [5:0] en_from_model();
        logic [5:0] e;
        e[0] = mdl[7][0];
        e[1] = mdl[7][2];
        e[2] = mdl[7][4];
        e[3] = mdl[6][0];
        e[4] = mdl[6][1];
        e[5] = mdl[6][2];
        return e;
    endfunction

    task automatic check_outs(input logic r, input string tag);
        ref_r = r;
        if (!r) app_en = en_from_model();
        repeat (4) @(negedge clk);
        expect_item(tag, {2'b00, r ? app_en : 6'h00});
        obs_val.push_back({2'b00, out_t});
        expect_item(tag, {2'b00, r ? ~app_en : 6'h3F});
        obs_val.push_back({2'b00, out_c});
    endtask

    task automatic check_released(input string tag);
        @(negedge clk);
        expect_item(tag, 8'h01);
        obs_val.push_back({7'b0, sda_line});
    endtask

    // write n payload bytes; the ones past register 7 must be dropped
    task automatic write_burst(input int n);
        logic ack;
        start_c();
        send_byte(8'hD2, ack); expect_item("R1 write address ack", 8'h00); obs_val.push_back({7'b0, ack});
        send_byte(8'h05, ack); expect_item("R2 command ack", 8'h00);       obs_val.push_back({7'b0, ack});
        send_byte(8'h3C, ack); expect_item("R2 count ack", 8'h00);         obs_val.push_back({7'b0, ack});
        for (int i = 0; i < n; i++) begin
            send_byte(pay[i], ack);
            expect_item(i < 8 ? "R3 data ack" : "R4 overflow ack", 8'h00);
            obs_val.push_back({7'b0, ack});
            if (i < 8) mdl[i] = pay[i];
        end
        stop_c();
        check_released("R11 released after write");
        if (!ref_r) app_en = en_from_model();
    endtask

    task automatic read_burst(input int n, input string tag);
        logic       ack;
        logic [7:0] b;
        start_c();
        send_byte(8'hD3, ack); expect_item("R1 read address ack", 8'h00); obs_val.push_back({7'b0, ack});
        recv_byte(n == 0, b);  expect_item("R5 count byte", 8'h08);       obs_val.push_back(b);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            expect_item(tag, i < 8 ? mdl[i] : 8'hFF);
            obs_val.push_back(b);
        end
        stop_c();
        check_released("R11 released after read");
    endtask

    initial begin
        logic ack;
        for (int i = 0; i < 8; i++) mdl[i] = (i == 6) ? 8'h8F : 8'hFF;
        app_en = 6'h3F;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state and plain fan-out
        check_released("R6 line free at reset");
        check_outs(1'b1, "R6 all pairs on, true high");
        check_outs(1'b0, "R7 true follows low reference");
        read_burst(8, "R6 default register");

        // short write stops after three data bytes
        pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33;
        write_burst(3);
        read_burst(8, "R3 partial write readback");

        // full write plus two overflow bytes, reads past the end
        pay[0] = 8'h5A; pay[1] = 8'hC3; pay[2] = 8'h0F; pay[3] = 8'h96;
        pay[4] = 8'h3C; pay[5] = 8'h71; pay[6] = 8'h8A; pay[7] = 8'hFB;
        pay[8] = 8'h00; pay[9] = 8'h00;
        write_burst(10);
        read_burst(10, "R4 R5 full readback and FFh tail");
        check_outs(1'b1, "R8 pairs 1 3 5 disabled");
        check_outs(1'b0, "R7 all low with low reference");

        // unknown address is ignored
        start_c();
        send_byte(8'hA0, ack); expect_item("R1 foreign address nack", 8'h01); obs_val.push_back({7'b0, ack});
        stop_c();
        read_burst(2, "R1 registers untouched by foreign address");

        // repeated start aborts: the following address is not answered
        start_c();
        send_byte(8'hD2, ack); expect_item("R10 first address ack", 8'h00); obs_val.push_back({7'b0, ack});
        send_byte(8'h00, ack); expect_item("R10 command ack", 8'h00);       obs_val.push_back({7'b0, ack});
        start_c();
        send_byte(8'hD2, ack); expect_item("R10 address after repeated start nack", 8'h01); obs_val.push_back({7'b0, ack});
        stop_c();
        read_burst(1, "R10 register 0 unchanged");

        // enable change while reference is held high
        check_outs(1'b1, "R9 before change");
        pay[7] = 8'hFA;
        write_burst(8);
        check_outs(1'b1, "R9 held while reference high");
        check_outs(1'b0, "R9 applied at low reference");
        check_outs(1'b1, "R9 new enable pattern");

        repeat (10) @(negedge clk);
        if (exp_val.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: got=%0d pending expected=0", exp_val.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule